// File: doc/BRIEF.md
# Multi-Axis Step Event Generator

This block turns queued linear moves into per-axis step requests for three stepper axes. A fixed-rate tick drives it. On every tick while a move is active, a signed time-distance accumulator is drawn down by the current velocity. When it goes negative a step event fires and a per-move reload value is added back. Each step event is shared among the axes by error-term counters, so every axis issues exactly its commanded number of steps over the move.

The velocity follows a trapezoid: accelerate, cruise, decelerate. It is updated once per ramp period of a fixed number of ticks. A hold request brings the move to a controlled stop, and a later resume picks the same move up where it stopped. Moves arrive on a valid/ready queue. Each accepted move sets the direction outputs at once, and its first step comes on a later tick. Signed position counters follow every step taken.

Top module: `step_event_gen`

## Requirements
- R1: A move is accepted only in a cycle where `tick_i` is high. On that tick `dir_o` takes the move's direction bits, where bit a belongs to axis a and a set bit means the negative direction. The remaining-event count is set to the move's event total.
- R2: Each axis error counter starts at half the event total, rounded down. On every step event the axis's step count is taken off that counter. If the result is negative, the axis steps, the event total is added back, and `pos_o` for that axis moves by one, down if its direction bit is set and up if it is clear. Each axis ends the move with exactly its commanded step count.
- R3: On each running tick the accumulator is reduced by the velocity, or by MIN_RATE when the velocity is below MIN_RATE. A negative result is a step event, and the move's reload value is then added back. The accumulator starts at the reload value.
- R4: No step is output for the tick that loads a move.
- R5: The ramp states are cruise, accelerate and decelerate. The ramp counter starts at TPA/2 on load and is set back to TPA each time it expires. In accelerate, each expiry adds the rate increment. A result at or above the nominal rate is clamped to the nominal rate and the state becomes cruise.
- R6: In decelerate, each expiry subtracts the increment if the velocity is above the increment. Otherwise the velocity is shifted right by one.
- R7: On load, the ramp starts in decelerate if the event total equals the decelerate-after threshold. Otherwise it starts in cruise if the initial rate equals the nominal rate, and in accelerate in all other cases.
- R8: When a step event leaves the remaining count nonzero and at or below the threshold, the ramp switches to decelerate. At exact equality the ramp counter becomes TPA/2 if the velocity is at the nominal rate, or TPA minus its current value otherwise.
- R9: While `hold_i` is high, a step event forces decelerate and sets the ramp counter to TPA/2 if the ramp was not already decelerating. A step event with the velocity at or below the increment stops the engine with no step: `held_o` rises, and no steps follow.
- R10: A one-cycle `resume_i` with `hold_i` low, given while held, restarts the move. The velocity restarts at 0 in accelerate with a TPA/2 ramp counter. The error counters and the remaining count carry on, so the move's step totals stay exact.
- R11: After the last event of a move, the next tick loads a waiting move without a done pulse. If no move is waiting, `done_o` pulses for one cycle and the engine goes idle.
- R12: No move is accepted while `hold_i` is high.
- R13: `step_o` bits are one-cycle pulses in the cycle after the tick that produced them. `pos_o` changes only together with a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Fixed-rate engine tick, one cycle wide |
| mv_valid_i | input | 1 | Move on the queue is valid |
| mv_ready_o | output | 1 | Move is taken in this cycle |
| mv_steps_i | input | NAX*EW | Per-axis step counts, axis a at [a*EW +: EW] |
| mv_dir_i | input | NAX | Per-axis direction bit, 1 = negative |
| mv_events_i | input | EW | Event total of the move |
| mv_reload_i | input | RW | Accumulator reload per step event |
| mv_init_rate_i | input | RW | Entry velocity |
| mv_nom_rate_i | input | RW | Cruise velocity |
| mv_rate_inc_i | input | RW | Velocity change per ramp period |
| mv_decel_after_i | input | EW | Remaining-event threshold that starts deceleration |
| hold_i | input | 1 | Hold request |
| resume_i | input | 1 | Restart after a hold stop |
| step_o | output | NAX | Per-axis step pulses |
| dir_o | output | NAX | Per-axis direction of the current move |
| pos_o | output | NAX*PW | Signed per-axis positions, axis a at [a*PW +: PW] |
| rate_o | output | RW | Current velocity |
| held_o | output | 1 | Stopped by a hold |
| done_o | output | 1 | One-cycle pulse when the queue runs dry |

## Verification
The assertions watch properties that must hold in every cycle. Moves are accepted only on ticks. No step comes out right after a load, and no step comes out while held. Steps appear only after a tick, positions move only together with a step, the done pulse lasts one cycle, and the velocity is zero when a hold is released. The exact tick of each step event, the per-ramp-period velocity values, the half-period and triangle reloads of the ramp counter, and the exact step totals across a hold and resume follow from whole move sequences. Only the directed scenarios can show those.

// File: rtl/step_gen_pkg.sv
package step_gen_pkg;
  typedef enum logic [1:0] {
    RAMP_CRUISE = 2'd0,
    RAMP_ACCEL  = 2'd1,
    RAMP_DECEL  = 2'd2
  } ramp_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_HELD = 2'd2
  } eng_e;
endpackage

// File: rtl/sg_rate_accum.sv
module sg_rate_accum #(
  parameter int RW       = 16,
  parameter int MIN_RATE = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [RW-1:0] reload_i,
  input  logic [RW-1:0] rate_i,
  output logic          fire_o
);
  localparam int AW = RW + 2;
  localparam logic [RW-1:0] MINR = RW'(MIN_RATE);

  logic signed [AW-1:0] acc_q, diff;
  logic [RW-1:0] reload_q, eff;

  assign eff    = (rate_i < MINR) ? MINR : rate_i;
  assign diff   = acc_q - $signed({2'b00, eff});
  assign fire_o = run_i & diff[AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      acc_q    <= $signed({2'b00, reload_i});
      reload_q <= reload_i;
    end else if (run_i) begin
      acc_q <= fire_o ? diff + $signed({2'b00, reload_q}) : diff;
    end
  end
endmodule

// File: rtl/sg_axis_bres.sv
module sg_axis_bres #(
  parameter int EW = 16,
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          evt_i,
  input  logic [EW-1:0] events_i,
  input  logic [EW-1:0] steps_i,
  input  logic          dir_i,
  output logic          step_o,
  output logic          dir_o,
  output logic [PW-1:0] pos_o
);
  localparam int CW = EW + 2;

  logic signed [CW-1:0] cnt_q, diff;
  logic [EW-1:0] steps_q, events_q;
  logic          dir_q;
  logic [PW-1:0] pos_q;

  assign diff   = cnt_q - $signed({2'b00, steps_q});
  assign step_o = evt_i & diff[CW-1];
  assign dir_o  = dir_q;
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      steps_q  <= '0;
      events_q <= '0;
      dir_q    <= 1'b0;
      pos_q    <= '0;
    end else if (load_i) begin
      cnt_q    <= $signed({2'b00, events_i >> 1});
      steps_q  <= steps_i;
      events_q <= events_i;
      dir_q    <= dir_i;
    end else if (evt_i) begin
      cnt_q <= step_o ? diff + $signed({2'b00, events_q}) : diff;
      if (step_o) pos_q <= dir_q ? pos_q - 1'b1 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/sg_ramp.sv
module sg_ramp
  import step_gen_pkg::*;
#(
  parameter int RW  = 16,
  parameter int TPA = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          start_decel_i,
  input  logic          resume_i,
  input  logic          run_i,
  input  logic          step_i,
  input  logic          hold_i,
  input  logic          decel_hit_i,
  input  logic          decel_eq_i,
  input  logic [RW-1:0] init_rate_i,
  input  logic [RW-1:0] nom_rate_i,
  input  logic [RW-1:0] inc_i,
  output logic [RW-1:0] rate_o,
  output logic [RW-1:0] rate_upd_o,
  output logic          stop_o
);
  localparam int CW = $clog2(TPA + 1);
  localparam logic [CW-1:0] HALF = CW'(TPA / 2);
  localparam logic [CW-1:0] FULL = CW'(TPA);

  ramp_e ramp_q, ramp_u, ramp_n;
  logic [CW-1:0] cnt_q, cnt_u, cnt_n;
  logic [RW-1:0] rate_q, rate_u, rate_n, nom_q, inc_q;
  logic [RW:0]   sum;

  assign sum = {1'b0, rate_q} + {1'b0, inc_q};

  // per-period velocity update
  always_comb begin
    rate_u = rate_q;
    ramp_u = ramp_q;
    cnt_u  = cnt_q;
    if (run_i && ramp_q != RAMP_CRUISE) begin
      cnt_u = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        cnt_u = FULL;
        if (ramp_q == RAMP_ACCEL) begin
          if (sum >= {1'b0, nom_q}) begin
            rate_u = nom_q;
            ramp_u = RAMP_CRUISE;
          end else begin
            rate_u = sum[RW-1:0];
          end
        end else if (rate_q > inc_q) begin
          rate_u = rate_q - inc_q;
        end else begin
          rate_u = rate_q >> 1;
        end
      end
    end
  end

  // step-event overrides
  always_comb begin
    rate_n = rate_u;
    ramp_n = ramp_u;
    cnt_n  = cnt_u;
    if (load_i) begin
      rate_n = init_rate_i;
      cnt_n  = HALF;
      if (start_decel_i)                  ramp_n = RAMP_DECEL;
      else if (init_rate_i == nom_rate_i) ramp_n = RAMP_CRUISE;
      else                                ramp_n = RAMP_ACCEL;
    end else if (resume_i) begin
      rate_n = '0;
      ramp_n = RAMP_ACCEL;
      cnt_n  = HALF;
    end else if (run_i && step_i) begin
      if (hold_i) begin
        if (ramp_u != RAMP_DECEL) begin
          ramp_n = RAMP_DECEL;
          cnt_n  = HALF;
        end
      end else if (decel_hit_i && ramp_u != RAMP_DECEL) begin
        ramp_n = RAMP_DECEL;
        if (decel_eq_i) cnt_n = (rate_u == nom_q) ? HALF : FULL - cnt_u;
      end
    end
  end

  assign rate_o     = rate_q;
  assign rate_upd_o = rate_u;
  assign stop_o     = run_i & step_i & hold_i & (rate_u <= inc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= RAMP_CRUISE;
      cnt_q  <= '0;
      rate_q <= '0;
      nom_q  <= '0;
      inc_q  <= '0;
    end else begin
      ramp_q <= ramp_n;
      cnt_q  <= cnt_n;
      rate_q <= rate_n;
      if (load_i) begin
        nom_q <= nom_rate_i;
        inc_q <= inc_i;
      end
    end
  end
endmodule

// File: rtl/step_event_gen.sv
module step_event_gen
  import step_gen_pkg::*;
#(
  parameter int NAX      = 3,
  parameter int EW       = 16,
  parameter int RW       = 16,
  parameter int PW       = 16,
  parameter int TPA      = 4,
  parameter int MIN_RATE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mv_valid_i,
  output logic              mv_ready_o,
  input  logic [NAX*EW-1:0] mv_steps_i,
  input  logic [NAX-1:0]    mv_dir_i,
  input  logic [EW-1:0]     mv_events_i,
  input  logic [RW-1:0]     mv_reload_i,
  input  logic [RW-1:0]     mv_init_rate_i,
  input  logic [RW-1:0]     mv_nom_rate_i,
  input  logic [RW-1:0]     mv_rate_inc_i,
  input  logic [EW-1:0]     mv_decel_after_i,
  input  logic              hold_i,
  input  logic              resume_i,
  output logic [NAX-1:0]    step_o,
  output logic [NAX-1:0]    dir_o,
  output logic [NAX*PW-1:0] pos_o,
  output logic [RW-1:0]     rate_o,
  output logic              held_o,
  output logic              done_o
);
  eng_e          state_q;
  logic          have_q, done_q;
  logic [EW-1:0] rem_q, da_q, rem_next;
  logic [NAX-1:0] step_q, ax_step;
  logic          load, tick_run, resume_go, fire, stop, step_evt, decel_hit, decel_eq;
  logic [RW-1:0] rate_upd;

  assign mv_ready_o = tick_i & ~hold_i &
                      ((state_q == ENG_IDLE) | ((state_q == ENG_RUN) & ~have_q));
  assign load      = mv_valid_i & mv_ready_o;
  assign tick_run  = tick_i & (state_q == ENG_RUN) & have_q;
  assign resume_go = (state_q == ENG_HELD) & resume_i & ~hold_i;
  assign step_evt  = fire & ~stop;
  assign rem_next  = rem_q - 1'b1;
  assign decel_eq  = (rem_next == da_q);
  assign decel_hit = (rem_next != '0) && (rem_next <= da_q);

  sg_rate_accum #(.RW(RW), .MIN_RATE(MIN_RATE)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .run_i    (tick_run),
    .reload_i (mv_reload_i),
    .rate_i   (rate_upd),
    .fire_o   (fire)
  );

  sg_ramp #(.RW(RW), .TPA(TPA)) u_ramp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .start_decel_i (mv_events_i == mv_decel_after_i),
    .resume_i      (resume_go),
    .run_i         (tick_run),
    .step_i        (fire),
    .hold_i        (hold_i),
    .decel_hit_i   (decel_hit),
    .decel_eq_i    (decel_eq),
    .init_rate_i   (mv_init_rate_i),
    .nom_rate_i    (mv_nom_rate_i),
    .inc_i         (mv_rate_inc_i),
    .rate_o        (rate_o),
    .rate_upd_o    (rate_upd),
    .stop_o        (stop)
  );

  for (genvar a = 0; a < NAX; a++) begin : g_ax
    sg_axis_bres #(.EW(EW), .PW(PW)) u_ax (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .evt_i    (step_evt),
      .events_i (mv_events_i),
      .steps_i  (mv_steps_i[a*EW +: EW]),
      .dir_i    (mv_dir_i[a]),
      .step_o   (ax_step[a]),
      .dir_o    (dir_o[a]),
      .pos_o    (pos_o[a*PW +: PW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      have_q  <= 1'b0;
      rem_q   <= '0;
      da_q    <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      step_q <= ax_step;
      done_q <= 1'b0;
      if (load) begin
        state_q <= ENG_RUN;
        have_q  <= (mv_events_i != '0);
        rem_q   <= mv_events_i;
        da_q    <= mv_decel_after_i;
      end else begin
        case (state_q)
          ENG_RUN: begin
            if (!have_q) begin
              if (tick_i && !hold_i) begin
                state_q <= ENG_IDLE;
                done_q  <= 1'b1;
              end
            end else if (tick_run && stop) begin
              state_q <= ENG_HELD;
            end else if (tick_run && step_evt) begin
              rem_q <= rem_next;
              if (rem_next == '0) have_q <= 1'b0;
            end
          end
          ENG_HELD: if (resume_go) state_q <= ENG_RUN;
          default: ;
        endcase
      end
    end
  end

  assign step_o = step_q;
  assign done_o = done_q;
  assign held_o = (state_q == ENG_HELD);
endmodule

// File: rtl/step_event_gen_chk.sv
module step_event_gen_chk #(
  parameter int NAX = 3,
  parameter int PW  = 16,
  parameter int RW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              mv_valid_i,
  input logic              mv_ready_o,
  input logic [NAX-1:0]    step_o,
  input logic [NAX*PW-1:0] pos_o,
  input logic [RW-1:0]     rate_o,
  input logic              held_o,
  input logic              done_o
);
  AST_READY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_ready_o |-> tick_i); // R1

  AST_NO_STEP_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_valid_i && mv_ready_o) |=> (step_o == '0)); // R4

  AST_STEP_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o != '0) |-> $past(tick_i)); // R13

  AST_POS_WITH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o != $past(pos_o)) |-> (step_o != '0)); // R2

  AST_HELD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_o |-> (step_o == '0)); // R9

  AST_RESUME_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_o) |-> (rate_o == '0)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

bind step_event_gen step_event_gen_chk #(.NAX(NAX), .PW(PW), .RW(RW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .mv_valid_i (mv_valid_i),
  .mv_ready_o (mv_ready_o),
  .step_o     (step_o),
  .pos_o      (pos_o),
  .rate_o     (rate_o),
  .held_o     (held_o),
  .done_o     (done_o)
);

// File: tb/step_event_gen_test.sv
`timescale 1ns/1ps
module step_event_gen_test;
  localparam int NAX = 3, EW = 16, RW = 16, PW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 1'b0, mv_valid = 1'b0, mv_ready, hold = 1'b0, resume = 1'b0;
  logic [NAX*EW-1:0] mv_steps = '0;
  logic [NAX-1:0]    mv_dir = '0, step_o, dir_o;
  logic [EW-1:0]     mv_events = '0, mv_da = '0;
  logic [RW-1:0]     mv_reload = '0, mv_init = '0, mv_nom = '0, mv_inc = '0, rate_o;
  logic [NAX*PW-1:0] pos_o;
  logic              held_o, done_o;

  always #10 clk = ~clk;

  step_event_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .mv_valid_i(mv_valid), .mv_ready_o(mv_ready),
    .mv_steps_i(mv_steps), .mv_dir_i(mv_dir), .mv_events_i(mv_events), .mv_reload_i(mv_reload),
    .mv_init_rate_i(mv_init), .mv_nom_rate_i(mv_nom), .mv_rate_inc_i(mv_inc),
    .mv_decel_after_i(mv_da), .hold_i(hold), .resume_i(resume), .step_o(step_o),
    .dir_o(dir_o), .pos_o(pos_o), .rate_o(rate_o), .held_o(held_o), .done_o(done_o)
  );

  int n_chk = 0, n_err = 0, tk = 0, ev_n = 0;
  int scnt [NAX];
  int ev_t [64];
  bit took = 0, seen_done = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int posv(input int a);
    return int'($signed(pos_o[a*PW +: PW]));
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; tick = 0; mv_valid = 0; hold = 0; resume = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    #1 took = mv_valid & mv_ready;
    @(negedge clk);
    tick = 1'b0;
    tk++;
    if (done_o) seen_done = 1;
    for (int a = 0; a < NAX; a++) if (step_o[a]) scnt[a]++;
    if (step_o != '0 && ev_n < 64) begin ev_t[ev_n] = tk; ev_n++; end
  endtask

  task automatic clr_log();
    tk = 0; ev_n = 0; seen_done = 0;
    for (int a = 0; a < NAX; a++) scnt[a] = 0;
  endtask

  task automatic put_move(input int sx, sy, sz, input logic [2:0] d, input int ev, rl, ini, nom, inc, da);
    mv_steps = {EW'(sz), EW'(sy), EW'(sx)};
    mv_dir = d; mv_events = EW'(ev); mv_reload = RW'(rl);
    mv_init = RW'(ini); mv_nom = RW'(nom); mv_inc = RW'(inc); mv_da = EW'(da);
    mv_valid = 1'b1;
  endtask

  task automatic load_move();
    do_tick();
    mv_valid = 1'b0;
    clr_log();
  endtask

  task automatic t_reset();
    do_reset();
    chk(step_o == 0 && dir_o == 0 && pos_o == 0, "R13 reset outputs", int'(step_o), 0);
    chk(rate_o == 0 && !held_o && !done_o, "R13 reset status", int'(rate_o), 0);
  endtask

  task automatic t_cruise();
    do_reset();
    put_move(6, 3, 0, 3'b010, 6, 100, 50, 50, 10, 0);
    do_tick();
    mv_valid = 0;
    chk(took, "R1 accepted on tick", int'(took), 1);
    chk(dir_o == 3'b010, "R1 dir on load", int'(dir_o), 2);
    chk(step_o == 0, "R4 no step on load tick", int'(step_o), 0);
    clr_log();
    repeat (13) do_tick();
    chk(ev_n == 6, "R2 event count", ev_n, 6);
    chk(ev_t[0] == 3, "R3 first event tick", ev_t[0], 3);
    chk(ev_t[1] == 5, "R3 second event tick", ev_t[1], 5);
    chk(scnt[0] == 6 && scnt[1] == 3 && scnt[2] == 0, "R2 per-axis steps", scnt[1], 3);
    chk(posv(0) == 6, "R2 x position", posv(0), 6);
    chk(posv(1) == -3, "R2 y position down", posv(1), -3);
    chk(rate_o == 50, "R7 cruise holds rate", int'(rate_o), 50);
    chk(!seen_done, "R11 no early done", int'(seen_done), 0);
    do_tick();
    chk(done_o == 1'b1, "R11 done after queue empty", int'(done_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R11 done one cycle", int'(done_o), 0);
  endtask

  task automatic t_minrate();
    do_reset();
    put_move(1, 0, 0, 3'b000, 1, 4, 0, 0, 1, 0);
    load_move();
    repeat (3) do_tick();
    chk(ev_n == 1 && ev_t[0] == 3, "R3 minimum rate pacing", ev_t[0], 3);
    chk(rate_o == 0, "R7 cruise at zero rate", int'(rate_o), 0);
  endtask

  task automatic t_accel();
    do_reset();
    put_move(2, 0, 0, 3'b000, 2, 1000, 0, 15, 10, 0);
    load_move();
    do_tick(); chk(rate_o == 0,  "R5 half period wait", int'(rate_o), 0);
    do_tick(); chk(rate_o == 10, "R5 first increment", int'(rate_o), 10);
    repeat (3) do_tick(); chk(rate_o == 10, "R5 full period wait", int'(rate_o), 10);
    do_tick(); chk(rate_o == 15, "R5 clamp to nominal", int'(rate_o), 15);
    repeat (4) do_tick(); chk(rate_o == 15, "R5 cruise after clamp", int'(rate_o), 15);
  endtask

  task automatic t_decel();
    do_reset();
    put_move(4, 0, 0, 3'b000, 4, 10000, 30, 30, 10, 4);
    load_move();
    repeat (2) do_tick(); chk(rate_o == 20, "R7 start in decel", int'(rate_o), 20);
    repeat (4) do_tick(); chk(rate_o == 10, "R6 subtract step", int'(rate_o), 10);
    repeat (4) do_tick(); chk(rate_o == 5,  "R6 halve at increment", int'(rate_o), 5);
    repeat (4) do_tick(); chk(rate_o == 2,  "R6 halve again", int'(rate_o), 2);
  endtask

  task automatic t_decel_entry();
    do_reset();
    put_move(4, 0, 0, 3'b000, 4, 100, 50, 50, 10, 2);
    load_move();
    repeat (6) do_tick(); chk(rate_o == 50, "R8 half period after cruise", int'(rate_o), 50);
    do_tick();            chk(rate_o == 40, "R8 decel after half period", int'(rate_o), 40);
    repeat (2) do_tick();
    chk(ev_n == 4 && ev_t[2] == 7 && ev_t[3] == 9, "R8 event ticks", ev_t[3], 9);
    do_reset();
    put_move(3, 0, 0, 3'b000, 3, 100, 40, 100, 20, 2);
    load_move();
    repeat (3) do_tick(); chk(rate_o == 60, "R8 accel before threshold", int'(rate_o), 60);
    do_tick();            chk(rate_o == 40, "R8 triangle counter reload", int'(rate_o), 40);
  endtask

  task automatic t_hold();
    int stopped;
    do_reset();
    put_move(20, 0, 0, 3'b000, 20, 100, 50, 50, 10, 0);
    load_move();
    repeat (4) do_tick();
    hold = 1'b1;
    for (int i = 0; i < 200 && !held_o; i++) do_tick();
    chk(held_o, "R9 hold stops engine", int'(held_o), 1);
    chk(rate_o <= 10, "R9 stop rate at or below increment", int'(rate_o), 10);
    stopped = scnt[0];
    chk(stopped < 20 && posv(0) == stopped, "R9 stopped mid move", stopped, posv(0));
    repeat (10) do_tick();
    chk(scnt[0] == stopped, "R9 no steps while held", scnt[0], stopped);
    @(negedge clk); hold = 1'b0; resume = 1'b1;
    @(negedge clk); resume = 1'b0;
    chk(!held_o && rate_o == 0, "R10 resume from zero", int'(rate_o), 0);
    for (int i = 0; i < 400 && !seen_done; i++) do_tick();
    chk(seen_done, "R10 move completes", int'(seen_done), 1);
    chk(posv(0) == 20 && scnt[0] == 20, "R10 exact total after resume", posv(0), 20);
  endtask

  task automatic t_queue();
    do_reset();
    put_move(1, 0, 0, 3'b111, 1, 100, 100, 100, 10, 0);
    hold = 1'b1;
    do_tick();
    chk(!took, "R12 no accept under hold", int'(took), 0);
    chk(dir_o == 3'b000, "R12 dir untouched under hold", int'(dir_o), 0);
    hold = 1'b0;
    load_move();
    chk(dir_o == 3'b111, "R1 dir after hold drops", int'(dir_o), 7);
    repeat (2) do_tick();
    chk(scnt[0] == 1 && posv(0) == -1, "R2 first move step", posv(0), -1);
    put_move(1, 0, 0, 3'b000, 1, 100, 100, 100, 10, 0);
    do_tick();
    mv_valid = 0;
    chk(took && !done_o, "R11 back-to-back pop", int'(done_o), 0);
    chk(dir_o == 3'b000, "R11 new dir", int'(dir_o), 0);
    repeat (2) do_tick();
    chk(posv(0) == 0, "R2 second move back", posv(0), 0);
    do_tick();
    chk(done_o, "R11 done at end", int'(done_o), 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_cruise();
    t_minrate();
    t_accel();
    t_decel();
    t_decel_entry();
    t_hold();
    t_queue();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
  end
endmodule